// File: doc/BRIEF.md
# Serial Right-Shift Execution Unit

This unit carries out a logical right shift one bit position per clock. A start request captures three inputs: a small count field taken from the instruction, a second register operand, and the value to be shifted. If the instruction count field is nonzero it is the shift amount. If it is zero, the shift amount comes from the low bits of the second register operand.

The value is copied unchanged into a result register. A down counter holding the shift amount then drives the loop. On each clock where the counter is nonzero, the result moves right by one bit with a zero entering at the top, and the counter drops by one. When the counter's zero test is true, the unit raises done for one clock. The result stays on its output until the next accepted start.

Any execution pipeline that lacks a barrel shifter can drop this unit in behind its issue logic. That pipeline then waits on done before it writes the result back.

Top module: `bitshift_unit`

## Requirements
- R1: After a synchronous reset, with rst high at a clock edge, `busy` and `done` are 0 and `result` is 0.
- R2: When `immCount` is nonzero at the accepted start, the shift amount equals `immCount`, and `countReg` has no effect on the result.
- R3: When `immCount` is zero at the accepted start, the shift amount equals `countReg[4:0]`. Bits 31..5 of `countReg` have no effect.
- R4: The final `result` equals the captured operand shifted right logically by the shift amount. Vacated high bits are 0.
- R5: When both count sources are zero, `result` equals the operand unchanged. `done` follows with no shift cycles.
- R6: A start is sampled high at clock edge E0 while the unit is idle. For a shift amount n, `done` is first high after edge E0+n+2.
- R7: `done` is high for exactly one clock per accepted start.
- R8: A start raised while `busy` is high is ignored. The result and the timing of the running operation are unchanged.
- R9: `busy` is high from the edge that accepts a start until the edge that ends the `done` cycle.
- R10: After `done`, `result` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a shift; accepted only when idle |
| immCount | input | 5 | Shift amount from the instruction; zero selects the register source |
| countReg | input | 32 | Second register operand; its low 5 bits are the fallback shift amount |
| operand | input | 32 | Value to be shifted |
| result | output | 32 | Shifted value, held after completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every immediate amount with the register source set to noise. It then sweeps every register amount with the immediate at zero and junk in the register's upper bits. A design that picked the wrong count source, or let the upper bits leak into the amount, would produce a wrong shift amount.

For every run the bench checks the exact cycle that `done` appears. An off-by-one in the zero test would show up as one extra shift, or one missing shift, and as a latency that differs from n+2. The both-zero case is covered; a counter that wrapped on zero would shift 31 times.

The bench raises a second start in mid-flight, which would corrupt the result of a design that restarts. It also applies a reset in mid-shift, which a design would fail if it left the unit busy.

// File: rtl/bitshift_pkg.sv
package bitshift_pkg;

  // Sequencer steps
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIXUP  = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture count, fallback count and operand
    logic fixCount;  // replace a zero count with the fallback
    logic shiftStep; // shift result by one and decrement count
  } stepCtl_t;

endpackage

// File: rtl/bitshift_ctrl.sv
module bitshift_ctrl
  import bitshift_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     cntZero,
  output stepCtl_t ctl,
  output logic     busy,
  output logic     done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        ctl.load = start;
        if (start) stateNext = ST_FIXUP;
      end
      ST_FIXUP: begin
        ctl.fixCount = 1'b1;
        stateNext    = ST_SHIFT;
      end
      ST_SHIFT: begin
        ctl.shiftStep = !cntZero;
        if (cntZero) stateNext = ST_FINISH;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  // done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // completion only after the datapath counter read zero
  assert_done_after_zero_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cntZero));

  // a start seen while busy must not produce a new load
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !ctl.load);

endmodule

// File: rtl/bitshift_dp.sv
module bitshift_dp
  import bitshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  stepCtl_t          ctl,
  input  logic [CNT_W-1:0]  immCount,
  input  logic [CNT_W-1:0]  regCount,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              cntZero
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  fallbackCnt;
  logic [DATA_W-1:0] res;

  assign cntZero = (cnt == '0);
  assign result  = res;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      fallbackCnt <= '0;
      res         <= '0;
    end else if (ctl.load) begin
      cnt         <= immCount;
      fallbackCnt <= regCount;
      res         <= operand;
    end else if (ctl.fixCount) begin
      if (cntZero) cnt <= fallbackCnt;
    end else if (ctl.shiftStep) begin
      res <= {1'b0, res[DATA_W-1:1]};
      cnt <= cnt - CNT_W'(1);
    end
  end

  // each shift step strictly lowers the counter
  assert_count_falls_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftStep |=> (cnt < $past(cnt)));

  // result is untouched when no load or shift strobe is given
  assert_result_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !(ctl.load || ctl.shiftStep) |=> $stable(res));

  // a shift step leaves a zero at the top bit
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftStep |=> !res[DATA_W-1]);

endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
  import bitshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  immCount,
  input  logic [DATA_W-1:0] countReg,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              done
);

  stepCtl_t ctl;
  logic     cntZero;
  logic     unusedRegHi;

  // the upper bits of the second operand play no part in the amount
  assign unusedRegHi = ^countReg[DATA_W-1:CNT_W];

  bitshift_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cntZero (cntZero),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  bitshift_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .immCount (immCount),
    .regCount (countReg[CNT_W-1:0]),
    .operand  (operand),
    .result   (result),
    .cntZero  (cntZero)
  );

endmodule

// File: tb/tb_bitshift_unit.sv
module tb_bitshift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  immCount = '0;
  logic [31:0] countReg = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  bitshift_unit dut (
    .clk(clk), .rst(rst), .start(start), .immCount(immCount),
    .countReg(countReg), .operand(operand), .result(result),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // interfere: raise a second start one cycle into the run
  task automatic runOp(input logic [4:0] imm, input logic [31:0] regv,
                       input logic [31:0] opnd, input bit interfere,
                       input string srcTag);
    int n;
    int lat;
    logic [31:0] exp;
    n   = (imm != 0) ? int'(imm) : int'(regv[4:0]);
    exp = opnd >> n;
    @(negedge clk);
    start = 1'b1; immCount = imm; countReg = regv; operand = opnd;
    @(negedge clk);
    start = 1'b0; immCount = ~imm; countReg = ~regv; operand = ~opnd;
    check(busy == 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (interfere && lat == 1) begin
        start = 1'b1; immCount = 5'd1; operand = 32'hFFFF_FFFF;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(lat == n + 2, interfere ? "R8" : "R6", "done latency",
          32'(lat), 32'(n + 2));
    check(result == exp, srcTag, "shift result (R4)", result, exp);
    if (n == 0)
      check(result == opnd, "R5", "no-shift result", result, opnd);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", 32'(done), 32'd0);
    check(busy == 1'b0, "R9", "busy cleared", 32'(busy), 32'd0);
    check(result == exp, "R10", "result held", result, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R1", "busy after reset", 32'(busy), 32'd0);
    check(done == 0, "R1", "done after reset", 32'(done), 32'd0);
    check(result == 0, "R1", "result after reset", result, 32'd0);

    // immediate source sweep, register source is noise
    for (int i = 1; i < 32; i++) begin
      runOp(5'(i), 32'hA5A5_A5A0 | 32'(31 - i), 32'hFFFF_FFFF, 0, "R2");
      runOp(5'(i), 32'h0000_001F, 32'h8000_0001 ^ (32'(i) << 7), 0, "R2");
    end

    // register source sweep, upper register bits are junk
    for (int i = 0; i < 32; i++) begin
      runOp(5'd0, 32'hDEAD_BEE0 | 32'(i), 32'hC3C3_5A5A, 0, "R3");
      runOp(5'd0, 32'hFFFF_FFE0 | 32'(i), 32'h8000_0000, 0, "R3");
    end

    // both sources zero
    runOp(5'd0, 32'hFFFF_FFE0, 32'h1234_5678, 0, "R5");

    // start while busy is ignored
    runOp(5'd9, 32'h0, 32'hF0F0_F0F0, 1, "R8");
    runOp(5'd0, 32'h0000_0003, 32'h0F0F_0F0F, 1, "R8");

    // reset in the middle of a long shift
    @(negedge clk);
    start = 1'b1; immCount = 5'd20; operand = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 0, "R1", "busy after mid-run reset", 32'(busy), 32'd0);
    check(result == 0, "R1", "result after mid-run reset", result, 32'd0);
    runOp(5'd4, 32'h0, 32'h0000_F000, 0, "R2");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule